// File: doc/BRIEF.md
# Latency-Insensitive Fork-and-Combine Dataflow Node

This block is one node of a network built from bounded queues. It reads two input queues, `a` and `b`, and writes two output queues: `c` receives `f(a, b)` and `d` receives a copy of `b`. Each output is produced once per logical tick. It is produced as soon as the inputs that output actually depends on are present and its own queue has room. `d` therefore never waits for `a`.

A done flag for each output records that the output has been produced in the current tick. When both flags are set, the node pops both input queues together and clears the flags, which starts the next tick. This split keeps the node free of false dependencies. As a result, `d` may be routed back into `a` through a small queue without locking up the loop. The function `f` is chosen at build time. The queue handshake is combinational on the node side: enqueue and dequeue strobes are derived from the queue status and the two flags.

Top module: `li_fork_node`

## Requirements
- R1: After reset, neither input is dequeued until `c` and `d` have each been enqueued once.
- R2: `c_enq` is high exactly when `c` has not been produced in the current tick, `a_nempty`, `b_nempty` and `c_nfull` are all high, and the cycle is not a finish cycle. `c_data` is then `f(a_head, b_head)`.
- R3: `d_enq` is high exactly when `d` has not been produced in the current tick and both `b_nempty` and `d_nfull` are high. `a_nempty` has no effect on it. `d_data` is then `b_head`.
- R4: Each output is enqueued at most once per tick. A tick ends at a finish cycle.
- R5: `a_deq` and `b_deq` are asserted together for a single cycle, the cycle after the later of the two output enqueues.
- R6: No enqueue on `c` or `d` happens in a finish cycle.
- R7: `FUNC = FN_ADD` makes `f` the sum modulo 2^DATA_W. `FUNC = FN_XOR` makes it the bitwise exclusive-or.
- R8: Route `d` into a one-entry queue that feeds `a` and starts empty. Every tick k then completes with `c = f(b_k, b_k)` and `d = b_k`, and the loop never deadlocks.
- R9: An output whose not-full signal is low is not enqueued. It is produced in a later cycle once room appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_nempty | input | 1 | Queue `a` holds an entry |
| a_head | input | DATA_W | Head entry of queue `a` |
| a_deq | output | 1 | Pop queue `a` |
| b_nempty | input | 1 | Queue `b` holds an entry |
| b_head | input | DATA_W | Head entry of queue `b` |
| b_deq | output | 1 | Pop queue `b` |
| c_nfull | input | 1 | Queue `c` has room |
| c_enq | output | 1 | Push onto queue `c` |
| c_data | output | DATA_W | Value pushed onto `c` |
| d_nfull | input | 1 | Queue `d` has room |
| d_enq | output | 1 | Push onto queue `d` |
| d_data | output | DATA_W | Value pushed onto `d` |

## Verification
The hardest situation to reach from the ports is a tick in which `d` must be produced while `a` is empty, because the only source of `a` is `d` itself. The bench closes that loop through a one-entry queue that starts empty. It also stalls the `c` queue on a fixed pattern and feeds `b` with gaps, so the two outputs finish in different orders across ticks. A second instance, driven step by step in open loop, covers blocked outputs, both outputs firing in the same cycle, and the exclusive-or function.

// File: rtl/li_node_pkg.sv
package li_node_pkg;
  typedef enum logic [0:0] {
    FN_ADD = 1'b0,
    FN_XOR = 1'b1
  } func_e;

  localparam int NUM_OUTS = 2;
  localparam int OUT_C    = 0;
  localparam int OUT_D    = 1;
endpackage

// File: rtl/li_func_unit.sv
module li_func_unit
  import li_node_pkg::*;
#(
  parameter int    DATA_W = 8,
  parameter func_e FUNC   = FN_ADD
) (
  input  logic [DATA_W-1:0] lhs_i,
  input  logic [DATA_W-1:0] rhs_i,
  output logic [DATA_W-1:0] res_o
);
  generate
    if (FUNC == FN_ADD) begin : g_add
      assign res_o = lhs_i + rhs_i;
    end else begin : g_xor
      assign res_o = lhs_i ^ rhs_i;
    end
  endgenerate
endmodule

// File: rtl/li_done_flag.sv
module li_done_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (clr_i) q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
  end
endmodule

// File: rtl/li_fork_node.sv
module li_fork_node
  import li_node_pkg::*;
#(
  parameter int    DATA_W = 8,
  parameter func_e FUNC   = FN_ADD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_nempty,
  input  logic [DATA_W-1:0] a_head,
  output logic              a_deq,
  input  logic              b_nempty,
  input  logic [DATA_W-1:0] b_head,
  output logic              b_deq,
  input  logic              c_nfull,
  output logic              c_enq,
  output logic [DATA_W-1:0] c_data,
  input  logic              d_nfull,
  output logic              d_enq,
  output logic [DATA_W-1:0] d_data
);
  logic [NUM_OUTS-1:0] ready;
  logic [NUM_OUTS-1:0] fire;
  logic [NUM_OUTS-1:0] done;
  logic                tick_end;

  // Readiness per output: only the inputs each output depends on.
  assign ready[OUT_C] = a_nempty & b_nempty & c_nfull;
  assign ready[OUT_D] = b_nempty & d_nfull;

  assign tick_end = &done;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_OUTS; gi++) begin : g_out
      assign fire[gi] = ready[gi] & ~done[gi];
      li_done_flag u_flag (
        .clk   (clk),
        .rst   (rst),
        .set_i (fire[gi]),
        .clr_i (tick_end),
        .q_o   (done[gi])
      );
    end
  endgenerate

  li_func_unit #(
    .DATA_W (DATA_W),
    .FUNC   (FUNC)
  ) u_fn (
    .lhs_i (a_head),
    .rhs_i (b_head),
    .res_o (c_data)
  );

  assign c_enq  = fire[OUT_C];
  assign d_enq  = fire[OUT_D];
  assign d_data = b_head;
  assign a_deq  = tick_end;
  assign b_deq  = tick_end;
endmodule

// File: rtl/li_fork_node_chk.sv
module li_fork_node_chk (
  input logic clk,
  input logic rst,
  input logic a_nempty,
  input logic b_nempty,
  input logic c_nfull,
  input logic d_nfull,
  input logic c_enq,
  input logic d_enq,
  input logic a_deq,
  input logic b_deq
);
  logic c_seen, d_seen;

  always_ff @(posedge clk) begin
    if (rst || a_deq) begin
      c_seen <= 1'b0;
      d_seen <= 1'b0;
    end else begin
      if (c_enq) c_seen <= 1'b1;
      if (d_enq) d_seen <= 1'b1;
    end
  end

  assert_c_guard_R2: assert property (@(posedge clk) disable iff (rst)
    c_enq |-> (a_nempty && b_nempty));
  assert_d_guard_R3: assert property (@(posedge clk) disable iff (rst)
    d_enq |-> b_nempty);
  assert_c_once_R4: assert property (@(posedge clk) disable iff (rst)
    c_enq |-> !c_seen);
  assert_d_once_R4: assert property (@(posedge clk) disable iff (rst)
    d_enq |-> !d_seen);
  assert_no_early_pop_R1: assert property (@(posedge clk) disable iff (rst)
    (a_deq || b_deq) |-> (c_seen && d_seen));
  assert_pop_prompt_R5: assert property (@(posedge clk) disable iff (rst)
    (c_seen && d_seen) |-> (a_deq && b_deq));
  assert_pop_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    a_deq |=> !a_deq);
  assert_finish_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    a_deq |-> (!c_enq && !d_enq));
  assert_c_full_R9: assert property (@(posedge clk) disable iff (rst)
    !c_nfull |-> !c_enq);
  assert_d_full_R9: assert property (@(posedge clk) disable iff (rst)
    !d_nfull |-> !d_enq);
endmodule

bind li_fork_node li_fork_node_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .a_nempty (a_nempty),
  .b_nempty (b_nempty),
  .c_nfull  (c_nfull),
  .d_nfull  (d_nfull),
  .c_enq    (c_enq),
  .d_enq    (d_enq),
  .a_deq    (a_deq),
  .b_deq    (b_deq)
);

// File: tb/li_fork_node_tb.sv
module li_fork_node_tb;
  import li_node_pkg::*;
  localparam int W     = 8;
  localparam int NTOK  = 40;
  localparam int LIMIT = 3000;

  logic clk = 1'b0;
  always #10 clk = ~clk;
  logic rst;

  // closed-loop instance (add)
  logic         a_ne, a_dq, b_ne, b_dq, c_nf, c_en, d_nf, d_en;
  logic [W-1:0] a_hd, b_hd, c_dt, d_dt;
  // open-loop instance (xor)
  logic         x_a_ne, x_a_dq, x_b_ne, x_b_dq, x_c_nf, x_c_en, x_d_nf, x_d_en;
  logic [W-1:0] x_a_hd, x_b_hd, x_c_dt, x_d_dt;

  logic         af_valid;
  logic [W-1:0] af_val;
  int           b_wr, b_rd;
  int           errors = 0, checks = 0;
  bit           finished = 1'b0;

  function automatic logic [W-1:0] bval(int k);
    return W'(k * 37 + 11);
  endfunction

  assign a_ne = af_valid;
  assign a_hd = af_val;
  assign d_nf = !af_valid;
  assign b_ne = (b_rd < b_wr);
  assign b_hd = bval(b_rd);

  li_fork_node #(.DATA_W(W), .FUNC(FN_ADD)) u_dut (
    .clk(clk), .rst(rst),
    .a_nempty(a_ne), .a_head(a_hd), .a_deq(a_dq),
    .b_nempty(b_ne), .b_head(b_hd), .b_deq(b_dq),
    .c_nfull(c_nf), .c_enq(c_en), .c_data(c_dt),
    .d_nfull(d_nf), .d_enq(d_en), .d_data(d_dt)
  );

  li_fork_node #(.DATA_W(W), .FUNC(FN_XOR)) u_dut_x (
    .clk(clk), .rst(rst),
    .a_nempty(x_a_ne), .a_head(x_a_hd), .a_deq(x_a_dq),
    .b_nempty(x_b_ne), .b_head(x_b_hd), .b_deq(x_b_dq),
    .c_nfull(x_c_nf), .c_enq(x_c_en), .c_data(x_c_dt),
    .d_nfull(x_d_nf), .d_enq(x_d_en), .d_data(x_d_dt)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic x_step(input bit ane, input logic [W-1:0] ah,
                        input bit bne, input logic [W-1:0] bh,
                        input bit cnf, input bit dnf,
                        input bit ec, input logic [W-1:0] ecd,
                        input bit ed, input logic [W-1:0] edd,
                        input bit ef, input string tag);
    @(posedge clk); #1;
    x_a_ne = ane; x_a_hd = ah; x_b_ne = bne; x_b_hd = bh;
    x_c_nf = cnf; x_d_nf = dnf;
    @(negedge clk);
    chk(x_c_en == ec, {tag, " c_enq"}, int'(x_c_en), int'(ec));
    if (ec) chk(x_c_dt == ecd, {tag, " c_data"}, int'(x_c_dt), int'(ecd));
    chk(x_d_en == ed, {tag, " d_enq"}, int'(x_d_en), int'(ed));
    if (ed) chk(x_d_dt == edd, {tag, " d_data"}, int'(x_d_dt), int'(edd));
    chk(x_a_dq == ef && x_b_dq == ef, {tag, " deq pair"},
        int'({x_a_dq, x_b_dq}), int'({ef, ef}));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    bit m_c, m_d, p_ec, p_ed, p_ef, p_adq, p_bdq, p_den;
    logic [W-1:0] p_ddt;
    bit exp_c, exp_d, exp_f;
    int nc, nd, nfin;
    rst = 1'b1; af_valid = 1'b0; af_val = '0; b_wr = 0; b_rd = 0; c_nf = 1'b1;
    x_a_ne = 0; x_a_hd = '0; x_b_ne = 0; x_b_hd = '0; x_c_nf = 0; x_d_nf = 0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(!c_en && !d_en && !a_dq && !b_dq, "R1 idle after reset",
        int'({c_en, d_en, a_dq, b_dq}), 0);
    m_c = 0; m_d = 0; p_ec = 0; p_ed = 0; p_ef = 0;
    p_adq = 0; p_bdq = 0; p_den = 0; p_ddt = '0;
    nc = 0; nd = 0; nfin = 0;
    for (int cyc = 0; cyc < LIMIT && nfin < NTOK; cyc++) begin
      @(posedge clk); #1;
      if (p_adq) af_valid = 1'b0;
      if (p_den) begin af_valid = 1'b1; af_val = p_ddt; end
      if (p_bdq) b_rd++;
      if ((cyc % 3) != 1 && b_wr < NTOK) b_wr++;
      c_nf = !((cyc % 7) == 2 || (cyc % 7) == 3);
      m_c = p_ef ? 1'b0 : (m_c | p_ec);
      m_d = p_ef ? 1'b0 : (m_d | p_ed);
      @(negedge clk);
      exp_c = !m_c && !(m_c && m_d) && a_ne && b_ne && c_nf;
      exp_d = !m_d && b_ne && d_nf;
      exp_f = m_c && m_d;
      chk(c_en == exp_c, "R2 R9 c enqueue", int'(c_en), int'(exp_c));
      chk(d_en == exp_d, "R3 R9 d enqueue", int'(d_en), int'(exp_d));
      chk(a_dq == exp_f && b_dq == exp_f, "R1 R5 R6 joint dequeue",
          int'({a_dq, b_dq}), int'({exp_f, exp_f}));
      if (c_en) begin
        chk(c_dt == W'(2 * int'(bval(nc))), "R8 R7 c stream", int'(c_dt),
            int'(W'(2 * int'(bval(nc)))));
        nc++;
      end
      if (d_en) begin
        chk(d_dt == bval(nd), "R3 R8 d stream", int'(d_dt), int'(bval(nd)));
        nd++;
      end
      if (a_dq) nfin++;
      p_ec = exp_c; p_ed = exp_d; p_ef = exp_f;
      p_adq = a_dq; p_bdq = b_dq; p_den = d_en; p_ddt = d_dt;
    end
    chk(nfin == NTOK, "R8 loop completes all ticks", nfin, NTOK);
    chk(nc == NTOK && nd == NTOK, "R4 R8 one c and one d per tick", nc * 1000 + nd,
        NTOK * 1000 + NTOK);

    // open-loop xor instance
    x_step(0, 8'h00, 1, 8'h5A, 1, 0, 0, 8'h00, 0, 8'h00, 0, "R9 d held while full");
    x_step(0, 8'h00, 1, 8'h5A, 1, 1, 0, 8'h00, 1, 8'h5A, 0, "R3 d without a");
    x_step(1, 8'h3C, 1, 8'h5A, 0, 1, 0, 8'h00, 0, 8'h00, 0, "R4 R9 no repeat, c held");
    x_step(1, 8'h3C, 1, 8'h5A, 1, 1, 1, 8'h66, 0, 8'h00, 0, "R7 xor result");
    x_step(1, 8'h3C, 1, 8'h5A, 1, 1, 0, 8'h00, 0, 8'h00, 1, "R5 R6 finish");
    x_step(1, 8'h3C, 1, 8'h5A, 1, 1, 1, 8'h66, 1, 8'h5A, 0, "R2 R3 same cycle");
    x_step(1, 8'h3C, 1, 8'h5A, 1, 1, 0, 8'h00, 0, 8'h00, 1, "R5 second finish");
    x_step(1, 8'hFF, 1, 8'h0F, 1, 1, 1, 8'hF0, 1, 8'h0F, 0, "R7 xor all ones");
    x_step(1, 8'hFF, 1, 8'h0F, 1, 1, 0, 8'h00, 0, 8'h00, 1, "R5 third finish");

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule